// File: doc/BRIEF.md
# Oversampling Asynchronous Serial Receiver

This block turns an asynchronous serial line into characters. A baud-rate tick is supplied from outside, one tick per oversampling period. The block samples the line once per tick, 16 times per bit normally or 8 times per bit in fast mode. It watches for a falling edge and treats that edge as a start bit only if the start bit still reads low at its centre. Each bit is then decided by a two-of-three vote over the three samples around the bit centre. Characters of 5 to 9 data bits are accepted, with an optional even or odd parity bit and one or two stop bits.

A finished character goes into a one-entry holding buffer. The buffer keeps the low eight data bits, the ninth bit, and per-character framing-error and parity-error flags. A ready flag stays set until the consumer acknowledges the read. An address-filter mode lets a node on a shared line ignore every character that does not carry the address marker. Turning the receiver off empties the buffer and abandons any character in progress.

Top module: `uart_ovs_rx`

## Requirements
- R1: After reset, rx_done, frm_err, par_err, rx_bit8 and rx_data are all zero.
- R2: With fast_mode=0 a bit lasts 16 ticks and is decided from samples 7, 8 and 9. With fast_mode=1 a bit lasts 8 ticks and is decided from samples 3, 4 and 5. Sample 0 is the tick that first sees the line low.
- R3: A bit value is the majority of its three centre samples, so a single disagreeing centre sample does not change the received bit.
- R4: If the vote at the centre of the start bit gives 1, the edge is treated as noise and no character is produced.
- R5: Data bits arrive least significant first. data_len gives the number of data bits as a binary count from 5 to 9 (below 5 acts as 5, above 9 acts as 9). Received bits appear in rx_data from bit 0 upward with unused upper bits zero. The ninth data bit appears on rx_bit8, which is 0 for shorter characters.
- R6: par_mode 0 or 1 means no parity bit, 2 means even parity and 3 means odd parity. The expected parity bit is the XOR of all data bits, inverted for odd. par_err is set for the held character when the received parity bit differs, and it is always 0 when parity is off.
- R7: frm_err is set for the held character when the first stop bit is decided as 0. Only the first stop bit is examined, and the receiver is ready for a new start edge right after that stop bit's centre.
- R8: rx_done rises when a character is stored and stays 1 until a one-cycle rd_ack, after which it is 0. frm_err and par_err are 0 whenever rx_done is 0.
- R9: If a character completes in the same cycle as rd_ack, the new character is stored and rx_done stays 1.
- R10: With addr_filter=1, a character whose last data bit (the ninth bit for 9-bit characters) is 0 is dropped. rx_done, rx_data and rx_bit8 keep their values. A character whose last data bit is 1 is stored normally.
- R11: With rx_en=0, rx_done and both error flags are 0 from the next cycle on. Any character in progress is abandoned, and line activity during that time produces no character.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| rx_en | input | 1 | Receiver enable; low flushes the buffer |
| baud_tick | input | 1 | One pulse per oversampling period |
| fast_mode | input | 1 | 1 selects 8 samples per bit, 0 selects 16 |
| data_len | input | 4 | Number of data bits, 5 to 9 |
| par_mode | input | 2 | 0/1 none, 2 even, 3 odd |
| addr_filter | input | 1 | Drop characters without the address marker |
| rx_line | input | 1 | Serial input line, idle high |
| rd_ack | input | 1 | Consumer has read the held character |
| rx_data | output | 8 | Low eight data bits of the held character |
| rx_bit8 | output | 1 | Ninth data bit of the held character |
| rx_done | output | 1 | A character is waiting to be read |
| frm_err | output | 1 | Held character had a zero first stop bit |
| par_err | output | 1 | Held character had a parity mismatch |

## Verification
Two things can happen in the same clock cycle: a character completes at the centre of its stop bit while the consumer acknowledges the previous character. The bench measures the fixed delay from a tick-aligned start edge to rx_done on one character. It then sends a second character with the same alignment and raises rd_ack exactly in the completion cycle. The new character must be visible on rx_data with rx_done still 1, and not lost to the acknowledge. A related case drops a filtered character while an earlier one sits unread, and the held data must come through unchanged.

// File: rtl/uart_ovs_pkg.sv
package uart_ovs_pkg;

  localparam int unsigned CHAR_W = 9;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_START,
    ST_DATA,
    ST_PAR,
    ST_STOP
  } rx_state_e;

  typedef struct packed {
    logic [CHAR_W-1:0] data;
    logic              frm_err;
    logic              par_err;
  } rx_char_t;

  // two-of-three decision
  function automatic logic vote3(input logic a, input logic b, input logic c);
    return (a & b) | (a & c) | (b & c);
  endfunction

  // requested data length clamped to the supported range
  function automatic logic [3:0] eff_len(input logic [3:0] req);
    if (req < 4'd5) return 4'd5;
    if (req > 4'd9) return 4'd9;
    return req;
  endfunction

  // expected parity bit over the received data bits
  function automatic logic par_calc(input logic [CHAR_W-1:0] d, input logic odd);
    return (^d) ^ odd;
  endfunction

endpackage

// File: rtl/uart_ovs_sync.sv
module uart_ovs_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic din,
  output logic dout
);
  logic [STAGES-1:0] q;

  generate
    if (STAGES == 1) begin : g_one
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '1;
        else        q <= din;
      end
    end else begin : g_chain
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '1;
        else        q <= {q[STAGES-2:0], din};
      end
    end
  endgenerate

  assign dout = q[STAGES-1];
endmodule

// File: rtl/uart_ovs_sampler.sv
module uart_ovs_sampler
  import uart_ovs_pkg::*;
#(
  parameter int unsigned OVS_NORM = 16,
  parameter int unsigned OVS_FAST = 8
) (
  input  logic clk,
  input  logic rst_n,
  input  logic tick,
  input  logic fast,
  input  logic busy,
  input  logic arm,
  input  logic line,
  output logic vote_stb,
  output logic vote_val,
  output logic bit_end
);
  localparam int unsigned CNT_W = $clog2(OVS_NORM);
  localparam logic [CNT_W-1:0] MID_N  = CNT_W'(OVS_NORM / 2);
  localparam logic [CNT_W-1:0] MID_F  = CNT_W'(OVS_FAST / 2);
  localparam logic [CNT_W-1:0] LAST_N = CNT_W'(OVS_NORM - 1);
  localparam logic [CNT_W-1:0] LAST_F = CNT_W'(OVS_FAST - 1);

  logic [CNT_W-1:0] cnt;
  logic [CNT_W-1:0] mid;
  logic [CNT_W-1:0] last;
  logic             s_lo;
  logic             s_mid;
  logic             step;

  assign mid  = fast ? MID_F : MID_N;
  assign last = fast ? LAST_F : LAST_N;
  assign step = busy && tick && !arm;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt   <= '0;
      s_lo  <= 1'b1;
      s_mid <= 1'b1;
    end else if (arm) begin
      cnt   <= CNT_W'(1);
      s_lo  <= 1'b1;
      s_mid <= 1'b1;
    end else if (!busy) begin
      cnt <= '0;
    end else if (tick) begin
      cnt <= (cnt == last) ? '0 : cnt + 1'b1;
      if (cnt == mid - 1'b1) s_lo  <= line;
      if (cnt == mid)        s_mid <= line;
    end
  end

  assign vote_stb = step && (cnt == mid + 1'b1);
  assign vote_val = vote3(s_lo, s_mid, line);
  assign bit_end  = step && (cnt == last);
endmodule

// File: rtl/uart_ovs_deframer.sv
module uart_ovs_deframer
  import uart_ovs_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       en,
  input  logic       tick,
  input  logic       line,
  input  logic [3:0] data_len,
  input  logic [1:0] par_mode,
  input  logic       addr_filter,
  input  logic       vote_stb,
  input  logic       vote_val,
  input  logic       bit_end,
  output logic       arm,
  output logic       busy,
  output logic       done,
  output logic       keep,
  output rx_char_t   char_out
);
  rx_state_e         st;
  logic [3:0]        bidx;
  logic [CHAR_W-1:0] shr;
  logic              pbit;
  logic [3:0]        nlen;
  logic              par_en;

  assign nlen   = eff_len(data_len);
  assign par_en = par_mode[1];
  assign busy   = (st != ST_IDLE);
  assign arm    = en && (st == ST_IDLE) && tick && !line;
  assign done   = en && (st == ST_STOP) && vote_stb;
  assign keep   = !addr_filter || shr[nlen - 4'd1];

  assign char_out.data    = shr;
  assign char_out.frm_err = !vote_val;
  assign char_out.par_err = par_en && (pbit != par_calc(shr, par_mode[0]));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st   <= ST_IDLE;
      bidx <= '0;
      shr  <= '0;
      pbit <= 1'b0;
    end else if (!en) begin
      st <= ST_IDLE;
    end else begin
      case (st)
        ST_IDLE: begin
          if (arm) begin
            st   <= ST_START;
            bidx <= '0;
            shr  <= '0;
            pbit <= 1'b0;
          end
        end
        ST_START: begin
          if (vote_stb && vote_val) st <= ST_IDLE;
          else if (bit_end)         st <= ST_DATA;
        end
        ST_DATA: begin
          if (vote_stb) shr[bidx] <= vote_val;
          if (bit_end) begin
            if (bidx == nlen - 4'd1) st <= par_en ? ST_PAR : ST_STOP;
            else                     bidx <= bidx + 4'd1;
          end
        end
        ST_PAR: begin
          if (vote_stb) pbit <= vote_val;
          if (bit_end)  st   <= ST_STOP;
        end
        ST_STOP: begin
          if (vote_stb) st <= ST_IDLE;
        end
        default: st <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/uart_ovs_rxbuf.sv
module uart_ovs_rxbuf
  import uart_ovs_pkg::*;
(
  input  logic     clk,
  input  logic     rst_n,
  input  logic     en,
  input  logic     load,
  input  rx_char_t char_in,
  input  logic     rd_ack,
  output logic     valid,
  output rx_char_t char_q
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      valid  <= 1'b0;
      char_q <= '0;
    end else if (!en) begin
      valid  <= 1'b0;
      char_q <= '0;
    end else if (load) begin
      valid  <= 1'b1;
      char_q <= char_in;
    end else if (rd_ack) begin
      valid <= 1'b0;
    end
  end
endmodule

// File: rtl/uart_ovs_rx.sv
module uart_ovs_rx #(
  parameter int unsigned OVS_NORM    = 16,
  parameter int unsigned OVS_FAST    = 8,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       rx_en,
  input  logic       baud_tick,
  input  logic       fast_mode,
  input  logic [3:0] data_len,
  input  logic [1:0] par_mode,
  input  logic       addr_filter,
  input  logic       rx_line,
  input  logic       rd_ack,
  output logic [7:0] rx_data,
  output logic       rx_bit8,
  output logic       rx_done,
  output logic       frm_err,
  output logic       par_err
);
  import uart_ovs_pkg::*;

  logic     line_s;
  logic     vote_stb;
  logic     vote_val;
  logic     bit_end;
  logic     arm;
  logic     busy;
  logic     frame_done;
  logic     frame_keep;
  logic     frame_take;
  rx_char_t frame_char;
  rx_char_t held_char;
  logic     held_valid;

  uart_ovs_sync #(.STAGES(SYNC_STAGES)) sync_i (
    .clk  (clk),
    .rst_n(rst_n),
    .din  (rx_line),
    .dout (line_s)
  );

  uart_ovs_sampler #(.OVS_NORM(OVS_NORM), .OVS_FAST(OVS_FAST)) smp_i (
    .clk     (clk),
    .rst_n   (rst_n),
    .tick    (baud_tick),
    .fast    (fast_mode),
    .busy    (busy),
    .arm     (arm),
    .line    (line_s),
    .vote_stb(vote_stb),
    .vote_val(vote_val),
    .bit_end (bit_end)
  );

  uart_ovs_deframer dfr_i (
    .clk        (clk),
    .rst_n      (rst_n),
    .en         (rx_en),
    .tick       (baud_tick),
    .line       (line_s),
    .data_len   (data_len),
    .par_mode   (par_mode),
    .addr_filter(addr_filter),
    .vote_stb   (vote_stb),
    .vote_val   (vote_val),
    .bit_end    (bit_end),
    .arm        (arm),
    .busy       (busy),
    .done       (frame_done),
    .keep       (frame_keep),
    .char_out   (frame_char)
  );

  assign frame_take = frame_done && frame_keep;

  uart_ovs_rxbuf buf_i (
    .clk    (clk),
    .rst_n  (rst_n),
    .en     (rx_en),
    .load   (frame_take),
    .char_in(frame_char),
    .rd_ack (rd_ack),
    .valid  (held_valid),
    .char_q (held_char)
  );

  assign rx_done = held_valid;
  assign rx_data = held_char.data[7:0];
  assign rx_bit8 = held_char.data[8];
  assign frm_err = held_valid && held_char.frm_err;
  assign par_err = held_valid && held_char.par_err;
endmodule

// File: rtl/uart_ovs_rx_chk.sv
module uart_ovs_rx_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       rx_en,
  input logic       baud_tick,
  input logic       rd_ack,
  input logic       par_on,
  input logic [3:0] data_len,
  input logic       rx_done,
  input logic       frm_err,
  input logic       par_err,
  input logic [7:0] rx_data,
  input logic       rx_bit8,
  input logic       vote_stb,
  input logic       frame_done,
  input logic       frame_keep,
  input logic       frame_take
);
  a_r11_disable_flushes: assert property (@(posedge clk) disable iff (!rst_n)
    !rx_en |=> (!rx_done && !frm_err && !par_err));

  a_r8_flags_need_char: assert property (@(posedge clk) disable iff (!rst_n)
    !rx_done |-> (!frm_err && !par_err));

  a_r8_ack_empties: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_ack && !frame_take) |=> !rx_done);

  a_r9_store_sets_done: assert property (@(posedge clk) disable iff (!rst_n)
    (frame_take && rx_en) |=> rx_done);

  a_r10_drop_keeps_buffer: assert property (@(posedge clk) disable iff (!rst_n)
    (frame_done && !frame_keep && rx_en && !rd_ack) |=>
      ($stable(rx_done) && $stable(rx_data) && $stable(rx_bit8)));

  a_r2_vote_on_tick: assert property (@(posedge clk) disable iff (!rst_n)
    vote_stb |-> baud_tick);

  a_r6_no_parity_err_when_off: assert property (@(posedge clk) disable iff (!rst_n)
    (frame_take && rx_en && !par_on) |=> !par_err);

  a_r5_no_ninth_bit_when_short: assert property (@(posedge clk) disable iff (!rst_n)
    (frame_take && rx_en && (data_len < 4'd9)) |=> !rx_bit8);
endmodule

bind uart_ovs_rx uart_ovs_rx_chk chk_i (
  .clk       (clk),
  .rst_n     (rst_n),
  .rx_en     (rx_en),
  .baud_tick (baud_tick),
  .rd_ack    (rd_ack),
  .par_on    (par_mode[1]),
  .data_len  (data_len),
  .rx_done   (rx_done),
  .frm_err   (frm_err),
  .par_err   (par_err),
  .rx_data   (rx_data),
  .rx_bit8   (rx_bit8),
  .vote_stb  (vote_stb),
  .frame_done(frame_done),
  .frame_keep(frame_keep),
  .frame_take(frame_take)
);

// File: tb/uart_ovs_rx_tb_top.sv
module uart_ovs_rx_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int DIV        = 4;
  localparam int WATCHDOG   = 150000;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       rx_en = 1'b0;
  logic       baud_tick;
  logic       fast_mode = 1'b0;
  logic [3:0] data_len = 4'd8;
  logic [1:0] par_mode = 2'd0;
  logic       addr_filter = 1'b0;
  logic       rx_line = 1'b1;
  logic       rd_ack;
  logic [7:0] rx_data;
  logic       rx_bit8;
  logic       rx_done;
  logic       frm_err;
  logic       par_err;

  logic mon_ack = 1'b0;
  logic man_ack = 1'b0;
  bit   auto_rd = 1'b0;
  int   cyc = 0;
  int   checks = 0;
  int   errors = 0;

  typedef struct packed {
    logic [8:0] d;
    logic       fe;
    logic       pe;
  } exp_t;
  exp_t  exp_q[$];
  string tag_q[$];

  assign rd_ack    = mon_ack | man_ack;
  assign baud_tick = (cyc % DIV == 0);

  always #(CLK_PERIOD/2) clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  uart_ovs_rx dut_i (
    .clk(clk), .rst_n(rst_n), .rx_en(rx_en), .baud_tick(baud_tick),
    .fast_mode(fast_mode), .data_len(data_len), .par_mode(par_mode),
    .addr_filter(addr_filter), .rx_line(rx_line), .rd_ack(rd_ack),
    .rx_data(rx_data), .rx_bit8(rx_bit8), .rx_done(rx_done),
    .frm_err(frm_err), .par_err(par_err)
  );

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  function automatic int ovs();
    return fast_mode ? 8 : 16;
  endfunction

  task automatic align();
    while (cyc % DIV != 0) @(negedge clk);
  endtask

  // one bit cell; optionally flip the centre tick
  task automatic drive_bit(input logic v, input bit glitch);
    for (int k = 0; k < ovs() * DIV; k++) begin
      rx_line = (glitch && (k / DIV == ovs() / 2)) ? ~v : v;
      @(negedge clk);
    end
  endtask

  task automatic send_frame(input logic [8:0] d, input logic bad_par,
                            input logic stop_v, input int gl_bit,
                            input bit sb, input string tag);
    logic [8:0] dm;
    logic       p;
    int         n;
    n  = int'(data_len);
    dm = d & 9'((1 << n) - 1);
    p  = (^dm) ^ par_mode[0];
    if (bad_par) p = ~p;
    if (sb) begin
      exp_q.push_back('{d: dm, fe: ~stop_v, pe: bad_par & par_mode[1]});
      tag_q.push_back(tag);
    end
    align();
    drive_bit(1'b0, 1'b0);
    for (int i = 0; i < n; i++) drive_bit(dm[i], gl_bit == i);
    if (par_mode[1]) drive_bit(p, 1'b0);
    drive_bit(stop_v, 1'b0);
    rx_line = 1'b1;
    repeat (ovs() * DIV * 2) @(negedge clk);
  endtask

  task automatic cfg(input int len, input logic [1:0] pm, input logic fast,
                     input logic filt);
    @(negedge clk);
    data_len    = 4'(len);
    par_mode    = pm;
    fast_mode   = fast;
    addr_filter = filt;
  endtask

  task automatic man_read();
    man_ack = 1'b1;
    @(negedge clk);
    man_ack = 1'b0;
    @(negedge clk);
  endtask

  // scoreboard monitor
  initial begin
    exp_t  e;
    string t;
    forever begin
      @(negedge clk);
      if (mon_ack) mon_ack = 1'b0;
      else if (auto_rd && rx_done) begin
        if (exp_q.size() == 0) begin
          chk(1'b0, "R10", "unexpected character", 32'(rx_data), 32'h0);
        end else begin
          e = exp_q.pop_front();
          t = tag_q.pop_front();
          chk((rx_data == e.d[7:0]) && (rx_bit8 == e.d[8]) &&
              (frm_err == e.fe) && (par_err == e.pe), t, "character",
              32'({rx_bit8, rx_data, frm_err, par_err}),
              32'({e.d, e.fe, e.pe}));
        end
        mon_ack = 1'b1;
      end
    end
  end

  initial begin
    repeat (WATCHDOG) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual %0d cycles expected fewer", WATCHDOG);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    int s;
    int lat;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    chk(!rx_done && !frm_err && !par_err, "R1", "flags after reset",
        32'({rx_done, frm_err, par_err}), 32'h0);
    chk(rx_data == 8'h00 && !rx_bit8, "R1", "data after reset",
        32'({rx_bit8, rx_data}), 32'h0);
    rx_en   = 1'b1;
    auto_rd = 1'b1;
    repeat (20) @(negedge clk);

    // R5 basic 8-bit, no parity, 16x
    cfg(8, 2'd0, 1'b0, 1'b0);
    send_frame(9'h0A5, 0, 1, -1, 1, "R5");
    send_frame(9'h03C, 0, 1, -1, 1, "R5");
    send_frame(9'h000, 0, 1, -1, 1, "R5");
    send_frame(9'h0FF, 0, 1, -1, 1, "R5");
    // R2 fast sampling
    cfg(8, 2'd0, 1'b1, 1'b0);
    send_frame(9'h05A, 0, 1, -1, 1, "R2");
    send_frame(9'h0C3, 0, 1, -1, 1, "R2");
    // R5 lengths
    cfg(5, 2'd0, 1'b0, 1'b0);
    send_frame(9'h01B, 0, 1, -1, 1, "R5");
    cfg(9, 2'd0, 1'b0, 1'b0);
    send_frame(9'h1C3, 0, 1, -1, 1, "R5");
    send_frame(9'h0AA, 0, 1, -1, 1, "R5");
    // R6 parity
    cfg(7, 2'd2, 1'b0, 1'b0);
    send_frame(9'h055, 0, 1, -1, 1, "R6");
    send_frame(9'h054, 1, 1, -1, 1, "R6");
    cfg(8, 2'd3, 1'b0, 1'b0);
    send_frame(9'h02A, 0, 1, -1, 1, "R6");
    send_frame(9'h081, 1, 1, -1, 1, "R6");
    cfg(9, 2'd2, 1'b1, 1'b0);
    send_frame(9'h101, 1, 1, -1, 1, "R6");
    // R7 frame error, then a clean character
    cfg(8, 2'd0, 1'b0, 1'b0);
    send_frame(9'h071, 0, 0, -1, 1, "R7");
    send_frame(9'h072, 0, 1, -1, 1, "R7");
    // R3 single centre-sample upsets
    send_frame(9'h0F0, 0, 1, 0, 1, "R3");
    send_frame(9'h00F, 0, 1, 3, 1, "R3");
    cfg(8, 2'd0, 1'b1, 1'b0);
    send_frame(9'h096, 0, 1, 5, 1, "R3");

    // R4 start glitches at both rates
    cfg(8, 2'd0, 1'b0, 1'b0);
    align();
    rx_line = 1'b0;
    repeat (2 * DIV) @(negedge clk);
    rx_line = 1'b1;
    repeat (16 * DIV * 12) @(negedge clk);
    chk(!rx_done && exp_q.size() == 0, "R4", "no char after glitch 16x",
        32'(rx_done), 32'h0);
    cfg(8, 2'd0, 1'b1, 1'b0);
    align();
    rx_line = 1'b0;
    repeat (DIV) @(negedge clk);
    rx_line = 1'b1;
    repeat (8 * DIV * 12) @(negedge clk);
    chk(!rx_done && exp_q.size() == 0, "R4", "no char after glitch 8x",
        32'(rx_done), 32'h0);
    send_frame(9'h0E7, 0, 1, -1, 1, "R4");

    // R10 address filter with auto read
    cfg(9, 2'd0, 1'b0, 1'b1);
    send_frame(9'h042, 0, 1, -1, 0, "R10");
    chk(!rx_done, "R10", "data char dropped", 32'(rx_done), 32'h0);
    send_frame(9'h142, 0, 1, -1, 1, "R10");
    cfg(8, 2'd0, 1'b0, 1'b1);
    send_frame(9'h011, 0, 1, -1, 0, "R10");
    send_frame(9'h091, 0, 1, -1, 1, "R10");
    chk(exp_q.size() == 0, "R10", "kept chars received", 32'(exp_q.size()), 32'h0);

    // R10 drop while a character is held
    auto_rd = 1'b0;
    cfg(9, 2'd0, 1'b0, 1'b1);
    send_frame(9'h1A6, 0, 1, -1, 0, "R10");
    send_frame(9'h05B, 0, 1, -1, 0, "R10");
    chk(rx_done && rx_data == 8'hA6 && rx_bit8, "R10", "held char survives drop",
        32'({rx_done, rx_bit8, rx_data}), 32'h3A6);
    man_read();
    // R8 acknowledge empties
    chk(!rx_done, "R8", "ack clears done", 32'(rx_done), 32'h0);

    // R9 completion coinciding with acknowledge
    cfg(8, 2'd0, 1'b0, 1'b0);
    align();
    s = cyc;
    fork
      send_frame(9'h033, 0, 1, -1, 0, "R9");
      begin
        while (!rx_done) @(negedge clk);
        lat = cyc - s;
      end
    join
    chk(rx_done && rx_data == 8'h33, "R8", "char held unread",
        32'({rx_done, rx_data}), 32'h133);
    align();
    s = cyc;
    fork
      send_frame(9'h0C6, 0, 1, -1, 0, "R9");
      begin
        while (cyc != s + lat - 1) @(negedge clk);
        man_ack = 1'b1;
        @(negedge clk);
        man_ack = 1'b0;
        chk(rx_done && rx_data == 8'hC6, "R9", "store wins over ack",
            32'({rx_done, rx_data}), 32'h1C6);
        @(negedge clk);
        chk(rx_done, "R9", "done stays set", 32'(rx_done), 32'h1);
      end
    join
    man_read();

    // R11 disable flushes a held character with an error
    send_frame(9'h0B4, 0, 0, -1, 0, "R11");
    chk(rx_done && frm_err, "R7", "frame error held", 32'({rx_done, frm_err}), 32'h3);
    rx_en = 1'b0;
    @(negedge clk);
    chk(!rx_done && !frm_err && !par_err, "R11", "flush on disable",
        32'({rx_done, frm_err, par_err}), 32'h0);
    send_frame(9'h0D2, 0, 1, -1, 0, "R11");
    rx_en = 1'b1;
    repeat (10) @(negedge clk);
    chk(!rx_done, "R11", "line ignored while off", 32'(rx_done), 32'h0);
    auto_rd = 1'b1;
    send_frame(9'h0D3, 0, 1, -1, 1, "R11");
    repeat (20) @(negedge clk);
    chk(exp_q.size() == 0, "R8", "scoreboard drained", 32'(exp_q.size()), 32'h0);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule